// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It takes the device from power-on to normal operation. After a start pulse it keeps the clock-enable and termination pins low for a programmed idle time, then raises clock-enable. It then issues the eleven-command setup sequence on the command bus and raises a done flag. Every command lasts a single clock. The cycles between commands carry NOP, and each wait is counted in ticks of a timebase input, so the same logic can be paced per clock or by a slower strobe.

The caller supplies three configuration words: the mode register value, the extended mode register (1) value and the extended mode register (2) value. The sequencer derives the DLL-reset, DLL-enable and calibration variants from these words itself, so the caller does not need to build them. Extended mode register (3) is always written as zero.

All pins are plain control and status signals. The block has no streaming data interface and no back-pressure.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and until start is sampled high, the outputs are: mem_cke low, mem_odt low, init_done low, and the bus deselected (mem_cs_n=1, mem_ras_n=mem_cas_n=mem_we_n=1, mem_ba=0, mem_addr=0). An asynchronous reset in mid-sequence returns the block to this state.
- R2: With tick held high, mem_cke goes high at the T_PWR+1'th clock edge after the edge that samples start. Once high, mem_cke stays high until reset. The bus is deselected while mem_cke is low and carries NOP ({cs,ras,cas,we}=0111) on every cycle that is not a command.
- R3: Exactly eleven commands are issued, in this order: precharge-all, EMR2 write, EMR3 write, EMR1 write, MR write with DLL reset, precharge-all, refresh, refresh, MR write without DLL reset, EMR1 calibration-default, EMR1 calibration-exit. Refresh is encoded as {cs,ras,cas,we}=0001.
- R4: Precharge-all is encoded as {cs,ras,cas,we}=0010, with address bit 10 high and every other address and bank bit zero.
- R5: A register write is encoded as {cs,ras,cas,we}=0000, with mem_ba selecting the target: 0 for MR, 1 for EMR1, 2 for EMR2, 3 for EMR3. EMR2 carries emr2_cfg unchanged. EMR3 carries an all-zero address.
- R6: Both EMR1 writes and the calibration-exit write carry emr1_cfg with bit 0 forced to 0 (DLL on) and bits 9:7 forced to 000. The calibration-default write forces bits 9:7 to 111 instead.
- R7: The first MR write carries mr_cfg with bit 8 (DLL reset) forced to 1. The second MR write carries mr_cfg with bit 8 forced to 0.
- R8: Let W be T_RP after a precharge-all, T_RFC after a refresh, and T_MRD after a register write. The next command appears at the edge after the W'th tick, with ticks counted from the edge that ends the command cycle. The first command follows the rise of mem_cke in the same way, with W = T_CKE. With tick held high, consecutive commands are therefore W+1 clocks apart.
- R9: init_done rises once the last wait has expired and at least T_DLL ticks have passed since the DLL-reset MR write. With tick held high, this is no earlier than T_DLL+1 clocks after that write. Once high, init_done stays high until reset.
- R10: A start pulse while the sequence runs, or after init_done, has no effect: no extra commands are issued and the timing does not change.
- R11: mem_odt is low at all times.
- R12: While tick is low, every pending wait is frozen, so no command is issued and init_done does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when the block is idle |
| tick | input | 1 | Timebase strobe; each sampled high counts one unit of wait |
| mr_cfg | input | 13 | Mode register value |
| emr1_cfg | input | 13 | Extended mode register (1) value |
| emr2_cfg | input | 13 | Extended mode register (2) value |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | 13 | Address bus |
| mem_cke | output | 1 | Clock enable to the device |
| mem_odt | output | 1 | On-die termination control, held low |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The first run holds tick high. Every wait then maps to an exact clock count, so an off-by-one in any timer or a wrong wait value shows up as a shifted command; this run also pulses start mid-sequence and after completion. A second run uses a random tick pattern and freezes tick for a long stretch after the first command. This separates logic that counts clocks from logic that counts ticks. It uses configuration words with the DLL-disable, DLL-reset and calibration bits already set, so a missing force of any of those bits is visible. A reset during the command phase checks that the sequence aborts cleanly.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  localparam int ADDR_W        = 13;
  localparam int BA_W          = 2;
  localparam int NSTEPS        = 11;
  localparam int DLL_RST_STEP  = 4;
  // bit positions decoded by the memory device
  localparam int BIT_DLL_OFF   = 0;
  localparam int BIT_DLL_RST   = 8;
  localparam int BIT_ALL_BANKS = 10;
  localparam int OCD_LSB       = 7;
  localparam int OCD_MSB       = 9;

  typedef enum logic [2:0] {K_DESEL, K_NOP, K_PREA, K_REF, K_MRW} cmd_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t pins_of(cmd_kind_e k);
    case (k)
      K_NOP:   return cmd_pins_t'(4'b0111);
      K_PREA:  return cmd_pins_t'(4'b0010);
      K_REF:   return cmd_pins_t'(4'b0001);
      K_MRW:   return cmd_pins_t'(4'b0000);
      default: return cmd_pins_t'(4'b1111);
    endcase
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr2_init_steps.sv
module ddr2_init_steps
  import ddr2_init_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 26,
  parameter int WAIT_W = 8,
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mr_cfg,
  input  logic [ADDR_W-1:0] emr1_cfg,
  input  logic [ADDR_W-1:0] emr2_cfg,
  output cmd_kind_e         kind,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [WAIT_W-1:0] wait_clks
);
  logic [ADDR_W-1:0] emr1_base, emr1_ocd, mr_rst, mr_run, prea_addr;

  always_comb begin
    emr1_base = emr1_cfg;
    emr1_base[BIT_DLL_OFF] = 1'b0;
    emr1_base[OCD_MSB:OCD_LSB] = '0;
    emr1_ocd = emr1_base;
    emr1_ocd[OCD_MSB:OCD_LSB] = '1;
    mr_rst = mr_cfg;
    mr_rst[BIT_DLL_RST] = 1'b1;
    mr_run = mr_cfg;
    mr_run[BIT_DLL_RST] = 1'b0;
    prea_addr = '0;
    prea_addr[BIT_ALL_BANKS] = 1'b1;
  end

  always_comb begin
    kind      = K_NOP;
    ba        = '0;
    addr      = '0;
    wait_clks = WAIT_W'(T_MRD);
    case (int'(step))
      0, 5: begin
        kind = K_PREA; addr = prea_addr; wait_clks = WAIT_W'(T_RP);
      end
      1: begin kind = K_MRW; ba = BA_W'(2); addr = emr2_cfg; end
      2: begin kind = K_MRW; ba = BA_W'(3); end
      3: begin kind = K_MRW; ba = BA_W'(1); addr = emr1_base; end
      4: begin kind = K_MRW; addr = mr_rst; end
      6, 7: begin kind = K_REF; wait_clks = WAIT_W'(T_RFC); end
      8: begin kind = K_MRW; addr = mr_run; end
      9: begin kind = K_MRW; ba = BA_W'(1); addr = emr1_ocd; end
      10: begin kind = K_MRW; ba = BA_W'(1); addr = emr1_base; end
      default: wait_clks = '0;
    endcase
  end
endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  a_r12_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/ddr2_cmd_drive.sv
module ddr2_cmd_drive
  import ddr2_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  cmd_pins_t pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= pins_of(K_DESEL);
      ba     <= '0;
      addr   <= '0;
    end else begin
      pins_q <= pins_of(kind);
      ba     <= ba_in;
      addr   <= addr_in;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;

  a_r4_prea_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[BIT_ALL_BANKS]);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int T_PWR = 100,
  parameter int T_CKE = 20,
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  parameter int T_RFC = 26,
  parameter int T_DLL = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [ADDR_W-1:0] mr_cfg,
  input  logic [ADDR_W-1:0] emr1_cfg,
  input  logic [ADDR_W-1:0] emr2_cfg,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cke,
  output logic              mem_odt,
  output logic              init_done
);
  localparam int WAIT_MAX = max_of(max_of(max_of(T_PWR, T_CKE), max_of(T_RP, T_MRD)), T_RFC);
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int DLL_W    = $clog2(T_DLL + 1);
  localparam int STEP_W   = $clog2(NSTEPS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PWR, ST_CKEW, ST_SEQ, ST_DONE} state_e;

  state_e              state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                cke_q, cke_d, done_q, done_d;
  logic                seq_load, seq_zero, dll_load, dll_zero, issue;
  logic [WAIT_W-1:0]   seq_val, tbl_wait;
  cmd_kind_e           tbl_kind, drv_kind;
  logic [BA_W-1:0]     tbl_ba, drv_ba;
  logic [ADDR_W-1:0]   tbl_addr, drv_addr;

  ddr2_init_steps #(
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .WAIT_W(WAIT_W), .STEP_W(STEP_W)
  ) u_steps (
    .step(step_q), .mr_cfg(mr_cfg), .emr1_cfg(emr1_cfg), .emr2_cfg(emr2_cfg),
    .kind(tbl_kind), .ba(tbl_ba), .addr(tbl_addr), .wait_clks(tbl_wait)
  );

  ddr2_wait_timer #(.CNT_W(WAIT_W)) u_seq_timer (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_val(seq_val),
    .tick(tick), .zero(seq_zero)
  );

  ddr2_wait_timer #(.CNT_W(DLL_W)) u_dll_timer (
    .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(DLL_W'(T_DLL)),
    .tick(tick), .zero(dll_zero)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cke_d    = cke_q;
    done_d   = done_q;
    seq_load = 1'b0;
    seq_val  = '0;
    dll_load = 1'b0;
    issue    = 1'b0;
    drv_kind = cke_q ? K_NOP : K_DESEL;
    drv_ba   = '0;
    drv_addr = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_PWR;
        seq_load = 1'b1;
        seq_val  = WAIT_W'(T_PWR);
      end
      ST_PWR: if (seq_zero) begin
        cke_d    = 1'b1;
        drv_kind = K_NOP;
        state_d  = ST_CKEW;
        seq_load = 1'b1;
        seq_val  = WAIT_W'(T_CKE);
      end
      ST_CKEW: if (seq_zero) issue = 1'b1;
      ST_SEQ: if (seq_zero) begin
        if (int'(step_q) == NSTEPS) begin
          if (dll_zero) begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end
        end else begin
          issue = 1'b1;
        end
      end
      default: ;
    endcase
    if (issue) begin
      drv_kind = tbl_kind;
      drv_ba   = tbl_ba;
      drv_addr = tbl_addr;
      seq_load = 1'b1;
      seq_val  = tbl_wait;
      step_d   = step_q + 1'b1;
      state_d  = ST_SEQ;
      dll_load = (int'(step_q) == DLL_RST_STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
    end
  end

  ddr2_cmd_drive u_drive (
    .clk(clk), .rst_n(rst_n), .kind(drv_kind), .ba_in(drv_ba), .addr_in(drv_addr),
    .cs_n(mem_cs_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n), .we_n(mem_we_n),
    .ba(mem_ba), .addr(mem_addr)
  );

  assign mem_cke   = cke_q;
  assign mem_odt   = 1'b0;
  assign init_done = done_q;

  a_r2_desel_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> mem_cs_n);

  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke);

  a_r8_one_cycle_command: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !(mem_ras_n && mem_cas_n && mem_we_n))
      |=> (mem_ras_n && mem_cas_n && mem_we_n));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r9_done_after_dll: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (dll_zero && mem_cke));

  a_r3_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) <= NSTEPS);
endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
  localparam int TP_PWR = 40;
  localparam int TP_CKE = 10;
  localparam int TP_RP  = 3;
  localparam int TP_MRD = 2;
  localparam int TP_RFC = 12;
  localparam int TP_DLL = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic [12:0] mr_cfg = '0, emr1_cfg = '0, emr2_cfg = '0;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_cke, mem_odt, init_done;
  logic [1:0]  mem_ba;
  logic [12:0] mem_addr;

  always #10 clk = ~clk;

  ddr2_init_seq #(
    .T_PWR(TP_PWR), .T_CKE(TP_CKE), .T_RP(TP_RP), .T_MRD(TP_MRD),
    .T_RFC(TP_RFC), .T_DLL(TP_DLL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .mr_cfg(mr_cfg), .emr1_cfg(emr1_cfg), .emr2_cfg(emr2_cfg),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
    .mem_cke(mem_cke), .mem_odt(mem_odt), .init_done(init_done)
  );

  int checks = 0, fails = 0, ncyc = 0;
  // reference model state
  int m_phase, m_cnt, m_step, m_dll, m_cke, m_done, e_kind, e_ba, e_addr;
  bit m_dll_set;
  int q_cyc[$], q_kind[$], q_ba[$], q_addr[$];
  int done_cyc = -1, cke_cyc = -1, start_cyc = -1;

  // kinds: 0 deselect, 1 NOP, 2 precharge-all, 3 refresh, 4 register write
  function automatic int exp_kind(int k);
    case (k) 0, 5: return 2; 6, 7: return 3; default: return 4; endcase
  endfunction
  function automatic int exp_ba(int k);
    case (k) 1: return 2; 2: return 3; 3, 9, 10: return 1; default: return 0; endcase
  endfunction
  function automatic int exp_addr(int k);
    int e1;
    e1 = int'(emr1_cfg) & ~32'h381;
    case (k)
      0, 5:  return 32'h400;
      1:     return int'(emr2_cfg);
      3, 10: return e1;
      4:     return int'(mr_cfg) | 32'h100;
      8:     return int'(mr_cfg) & ~32'h100;
      9:     return e1 | 32'h380;
      default: return 0;
    endcase
  endfunction
  function automatic int exp_wait(int k);
    case (k) 0, 5: return TP_RP; 6, 7: return TP_RFC; default: return TP_MRD; endcase
  endfunction
  function automatic logic [3:0] pins_for(int kind);
    case (kind) 1: return 4'b0111; 2: return 4'b0010; 3: return 4'b0001;
      4: return 4'b0000; default: return 4'b1111; endcase
  endfunction

  task automatic model_reset();
    m_phase = 0; m_cnt = 0; m_step = 0; m_dll = 0; m_cke = 0; m_done = 0;
    e_kind = 0; e_ba = 0; e_addr = 0;
  endtask

  task automatic model_issue(int k);
    e_kind = exp_kind(k); e_ba = exp_ba(k); e_addr = exp_addr(k);
    m_cnt = exp_wait(k); m_step = k + 1; m_phase = 3;
    if (k == 4) begin m_dll = TP_DLL; m_dll_set = 1'b1; end
  endtask

  task automatic model_adv(bit s, bit t);
    int old_dll;
    old_dll = m_dll; m_dll_set = 1'b0;
    e_kind = m_cke ? 1 : 0; e_ba = 0; e_addr = 0;
    case (m_phase)
      0: if (s) begin m_phase = 1; m_cnt = TP_PWR; end
      1: if (m_cnt == 0) begin m_cke = 1; e_kind = 1; m_phase = 2; m_cnt = TP_CKE; end
         else if (t) m_cnt--;
      2: if (m_cnt == 0) model_issue(m_step); else if (t) m_cnt--;
      3: if (m_cnt == 0) begin
           if (m_step == 11) begin
             if (old_dll == 0) begin m_done = 1; m_phase = 4; end
           end else model_issue(m_step);
         end else if (t) m_cnt--;
      default: ;
    endcase
    if (!m_dll_set && old_dll > 0 && t) m_dll = old_dll - 1;
  endtask

  task automatic compare();
    logic [3:0] act, exp;
    string tag;
    act = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    exp = pins_for(e_kind);
    checks++;
    if (mem_cke !== m_cke[0] || init_done !== m_done[0] || mem_odt !== 1'b0 ||
        act !== exp || mem_ba !== e_ba[1:0] || mem_addr !== e_addr[12:0]) begin
      fails++;
      if (mem_cke !== m_cke[0]) tag = "R2";
      else if (init_done !== m_done[0]) tag = "R9";
      else if (mem_odt !== 1'b0) tag = "R11";
      else tag = "R3";
      $display("FAIL %s cycle %0d: got cke=%b done=%b odt=%b cmd=%b ba=%0d addr=%h, expected cke=%0d done=%0d odt=0 cmd=%b ba=%0d addr=%h",
               tag, ncyc, mem_cke, init_done, mem_odt, act, mem_ba, mem_addr,
               m_cke, m_done, exp, e_ba, e_addr[12:0]);
    end
    if (mem_cs_n === 1'b0 && act !== 4'b0111) begin
      q_cyc.push_back(ncyc); q_ba.push_back(int'(mem_ba)); q_addr.push_back(int'(mem_addr));
      q_kind.push_back(act == 4'b0010 ? 2 : act == 4'b0001 ? 3 : act == 4'b0000 ? 4 : 9);
    end
    if (init_done === 1'b1 && done_cyc < 0) done_cyc = ncyc;
    if (mem_cke === 1'b1 && cke_cyc < 0) cke_cyc = ncyc;
  endtask

  task automatic cyc(bit s, bit t);
    start = s; tick = t;
    model_adv(s, t);
    @(negedge clk);
    ncyc++;
    compare();
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    q_cyc.delete(); q_kind.delete(); q_ba.delete(); q_addr.delete();
    done_cyc = -1; cke_cyc = -1; start_cyc = -1;
  endtask

  task automatic do_reset(int n);
    rst_n = 1'b0; start = 1'b0; tick = 1'b0;
    model_reset();
    for (int i = 0; i < n; i++) begin @(negedge clk); ncyc++; compare(); end
    rst_n = 1'b1;
  endtask

  task automatic check_idle(string what);
    check(mem_cke === 1'b0, "R1", {what, " cke"}, int'(mem_cke), 0);
    check(mem_cs_n === 1'b1, "R1", {what, " cs_n"}, int'(mem_cs_n), 1);
    check(init_done === 1'b0, "R1", {what, " done"}, int'(init_done), 0);
  endtask

  task automatic check_order(bit exact_timing);
    check(q_cyc.size() == 11, "R3", "command count", q_cyc.size(), 11);
    for (int k = 0; k < 11 && k < q_cyc.size(); k++) begin
      check(q_kind[k] == exp_kind(k), "R3", $sformatf("kind of command %0d", k), q_kind[k], exp_kind(k));
      check(q_ba[k] == exp_ba(k), "R5", $sformatf("bank of command %0d", k), q_ba[k], exp_ba(k));
      if (k == 0 || k == 5)
        check(q_addr[k] == 32'h400, "R4", $sformatf("addr of command %0d", k), q_addr[k], 32'h400);
      else if (k == 3 || k == 9 || k == 10)
        check(q_addr[k] == exp_addr(k), "R6", $sformatf("addr of command %0d", k), q_addr[k], exp_addr(k));
      else if (k == 4 || k == 8)
        check(q_addr[k] == exp_addr(k), "R7", $sformatf("addr of command %0d", k), q_addr[k], exp_addr(k));
      else
        check(q_addr[k] == exp_addr(k), "R5", $sformatf("addr of command %0d", k), q_addr[k], exp_addr(k));
    end
    if (q_cyc.size() == 11) begin
      check(q_addr[2] == 0, "R5", "EMR3 address", q_addr[2], 0);
      check((q_addr[3] & 1) == 0, "R6", "EMR1 DLL bit", q_addr[3] & 1, 0);
      check(((q_addr[4] >> 8) & 1) == 1, "R7", "DLL reset bit first MR", (q_addr[4] >> 8) & 1, 1);
      check(((q_addr[8] >> 8) & 1) == 0, "R7", "DLL reset bit second MR", (q_addr[8] >> 8) & 1, 0);
      check(done_cyc - q_cyc[4] >= TP_DLL + 1, "R9", "clocks from DLL reset to done",
            done_cyc - q_cyc[4], TP_DLL + 1);
      if (exact_timing) begin
        check(q_cyc[0] - cke_cyc == TP_CKE + 1, "R8", "cke rise to first command",
              q_cyc[0] - cke_cyc, TP_CKE + 1);
        for (int k = 0; k < 10; k++)
          check(q_cyc[k+1] - q_cyc[k] == exp_wait(k) + 1, "R8",
                $sformatf("gap after command %0d", k), q_cyc[k+1] - q_cyc[k], exp_wait(k) + 1);
        check(done_cyc - q_cyc[4] == TP_DLL + 1, "R9", "done timing with tick high",
              done_cyc - q_cyc[4], TP_DLL + 1);
      end
    end
  endtask

  initial begin
    int sz;
    // run A: tick held high
    mr_cfg = 13'h0632; emr1_cfg = 13'h0044; emr2_cfg = 13'h0080;
    do_reset(3);
    check_idle("after reset");
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'($urandom_range(0, 1)));
    check_idle("idle without start");
    cyc(1'b1, 1'b1);
    start_cyc = ncyc;
    for (int i = 0; i < 3000 && done_cyc < 0; i++) cyc(i == 150, 1'b1);
    if (done_cyc < 0) check(1'b0, "R9", "watchdog run A", 0, 1);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1);
    check(q_cyc.size() == 11, "R10", "commands after stray starts", q_cyc.size(), 11);
    check(init_done === 1'b1, "R9", "done held", int'(init_done), 1);
    check(cke_cyc - start_cyc == TP_PWR + 1, "R2", "start to cke rise", cke_cyc - start_cyc, TP_PWR + 1);
    check_order(1'b1);

    // reset in the middle of the command phase
    clear_obs();
    do_reset(2);
    cyc(1'b1, 1'b1);
    for (int i = 0; i < 70; i++) cyc(1'b0, 1'b1);
    check(q_cyc.size() > 0, "R1", "commands before abort", q_cyc.size(), 1);
    do_reset(2);
    check_idle("reset mid-sequence");
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1);
    check_idle("idle after abort");

    // run B: random tick, forced bits preset in configuration
    clear_obs();
    mr_cfg = 13'h1FFF; emr1_cfg = 13'h1FFF; emr2_cfg = 13'h0A5A;
    cyc(1'b1, 1'($urandom_range(0, 1)));
    for (int i = 0; i < 3000 && q_cyc.size() == 0; i++) cyc(1'b0, 1'($urandom_range(0, 1)));
    sz = q_cyc.size();
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0);
    check(q_cyc.size() == sz, "R12", "commands while tick low", q_cyc.size(), sz);
    check(init_done === 1'b0, "R12", "done while tick low", int'(init_done), 0);
    for (int i = 0; i < 5000 && done_cyc < 0; i++) cyc(1'b0, 1'($urandom_range(0, 1)));
    if (done_cyc < 0) check(1'b0, "R9", "watchdog run B", 0, 1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);
    check_order(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule